// File: doc/BRIEF.md
# Dual Decade Counter with Selectable BCD or Bi-Quinary Chaining

This block holds a set of independent four-digit-bit decade counters, two by default, all clocked by one system clock. Each counter is built from a one-bit toggle stage (QA) and a three-bit modulo-five stage (QD QC QB). Each stage has its own count strobe. A stage advances when its strobe goes from high to low, and the block finds that edge by comparing the strobe with its value one clock earlier.

A per-counter chain select fixes how the two stages are linked. With the select low, the counter runs in BCD: the toggle stage takes the external strobe, and its falling output advances the modulo-five stage. QD QC QB QA then read 0 through 9 in binary. With the select high, the counter runs in bi-quinary: the modulo-five stage takes the external strobe, and its wrap from 4 back to 0 flips QA. QA then becomes a square wave at one tenth of the strobe rate, low for five counts and high for five. A chained stage advances in the same clock as the stage that feeds it, so a whole counter never shows an intermediate value.

Each counter has its own clear. Clear wins over any count edge in the same cycle. Every stage output is registered and available in parallel. A counter's output can be wired to another counter's strobe to divide by 100.

Top module: `decade_pair`

## Requirements
- R1: While `rst` is high at a clock edge, every counter output is 0 after that edge.
- R2: With `chain_sel[i]`=0 (BCD), each falling edge on `tick_two[i]` advances the counter by one. `cnt_q[4i+3:4i]` = {QD,QC,QB,QA} shows the count 0..9 in binary and wraps from 9 to 0. The output moves straight from one value to the next in a single clock.
- R3: With `chain_sel[i]`=0, edges on `tick_five[i]` leave that counter unchanged.
- R4: With `chain_sel[i]`=1 (bi-quinary), each falling edge on `tick_five[i]` advances the count n by one, mod 10. The output is {QD,QC,QB} = n mod 5 and QA = 1 when n >= 5.
- R5: With `chain_sel[i]`=1, edges on `tick_two[i]` leave that counter unchanged.
- R6: In bi-quinary mode QA is low for counts 0..4 and high for counts 5..9.
- R7: A counter advances only on a high-to-low strobe transition. A strobe held high, a rising edge, or a strobe held low causes no further change. The output changes at the first clock edge that samples the strobe low after a high sample.
- R8: `clr[i]` high at a clock edge forces counter i to 0, even when a count edge arrives in the same cycle. Other counters are not affected.
- R9: A strobe that falls while its counter is held in clear, and is still low when clear is released, does not cause a count.
- R10: Counters are independent. With counter 0 in bi-quinary mode and its QA driving counter 1's `tick_two`, 100 strobes on counter 0 bring both counters back to 0. After 55 strobes, counter 0 shows 5 and counter 1 shows 5.
- R11: {QD,QC,QB} never holds 5, 6 or 7. If such a code were ever present, the next count would return it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all counters |
| clr | input | NUM_CNT | Per-counter synchronous clear, active high |
| chain_sel | input | NUM_CNT | Per-counter chaining: 0 = BCD, 1 = bi-quinary |
| tick_two | input | NUM_CNT | Count strobe of each toggle stage (falling edge counts) |
| tick_five | input | NUM_CNT | Count strobe of each modulo-five stage (falling edge counts) |
| cnt_q | output | 4*NUM_CNT | Counter i at bits 4i+3..4i as {QD,QC,QB,QA} |

## Verification
The bench builds the block with NUM_CNT = 2, the smallest value that lets one counter run in BCD while the other runs in bi-quinary. That value also allows the divide-by-100 cascade, with counter 0's QA fed back into counter 1's toggle strobe. With two counters, a clear or a strobe on one counter can be checked for no effect on its neighbour. The cascade takes each counter through its full wrap, including the 9 to 0 carry, which is the cycle where both stages move together.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int DIG_W  = 4;
  localparam int QUIN_W = 3;
  localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;

  typedef enum logic {
    CHAIN_BCD = 1'b0,
    CHAIN_BIQ = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/strobe_fall.sv
module strobe_fall (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic din,
  output logic fall
);
  logic prev_q;

  // Sample history is wiped on clear so a low input at release is not an edge.
  always_ff @(posedge clk) begin
    if (rst || clr) prev_q <= 1'b0;
    else            prev_q <= din;
  end

  assign fall = prev_q & ~din & ~clr & ~rst;
endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) bit_q <= 1'b0;
    else if (adv)   bit_q <= ~bit_q;
  end
endmodule

// File: rtl/quinary_stage.sv
module quinary_stage
  import decade_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [QUIN_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code_q <= '0;
    end else if (adv) begin
      // last legal code and any unused code return to zero
      if (code_q >= QUIN_LAST) code_q <= '0;
      else                     code_q <= code_q + 1'b1;
    end
  end
endmodule

// File: rtl/decade_unit.sv
module decade_unit
  import decade_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  chain_mode_e      chain,
  input  logic             tick_two,
  input  logic             tick_five,
  output logic [DIG_W-1:0] q
);
  logic              fall_two, fall_five;
  logic              adv_two, adv_five;
  logic              qa;
  logic [QUIN_W-1:0] quin;

  strobe_fall u_fall_two (
    .clk(clk), .rst(rst), .clr(clr), .din(tick_two), .fall(fall_two)
  );
  strobe_fall u_fall_five (
    .clk(clk), .rst(rst), .clr(clr), .din(tick_five), .fall(fall_five)
  );

  // Chaining resolved without a combinational loop: the feeding stage's
  // falling output is predicted from its current state and its own advance.
  always_comb begin
    if (chain == CHAIN_BIQ) begin
      adv_five = fall_five;
      adv_two  = fall_five & (quin == QUIN_LAST);
    end else begin
      adv_two  = fall_two;
      adv_five = fall_two & qa;
    end
  end

  toggle_stage u_two (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv_two), .bit_q(qa)
  );
  quinary_stage u_five (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv_five), .code_q(quin)
  );

  assign q = {quin, qa};
endmodule

// File: rtl/decade_pair.sv
module decade_pair
  import decade_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       clr,
  input  logic [NUM_CNT-1:0]       chain_sel,
  input  logic [NUM_CNT-1:0]       tick_two,
  input  logic [NUM_CNT-1:0]       tick_five,
  output logic [DIG_W*NUM_CNT-1:0] cnt_q
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_unit
    decade_unit u_unit (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr[g]),
      .chain    (chain_mode_e'(chain_sel[g])),
      .tick_two (tick_two[g]),
      .tick_five(tick_five[g]),
      .q        (cnt_q[DIG_W*g +: DIG_W])
    );
  end
endmodule

// File: rtl/decade_pair_chk.sv
module decade_pair_chk
  import decade_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CNT-1:0]       clr,
  input logic [NUM_CNT-1:0]       chain_sel,
  input logic [NUM_CNT-1:0]       tick_two,
  input logic [NUM_CNT-1:0]       tick_five,
  input logic [DIG_W*NUM_CNT-1:0] cnt_q
);
  function automatic logic [3:0] bcd_succ(logic [3:0] v);
    return (v >= 4'd9) ? 4'd0 : v + 4'd1;
  endfunction

  function automatic logic [3:0] biq_succ(logic [3:0] v);
    logic [2:0] hi;
    hi = v[3:1];
    if (hi >= 3'd4) return {3'd0, ~v[0]};
    return {hi + 3'd1, v[0]};
  endfunction

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (cnt_q == '0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R8
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clr[g] |=> (cnt_q[4*g +: 4] == 4'd0));
    // R11
    a_r11_quin_range: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[4*g+1 +: 3] <= 3'd4));
    // R2
    a_r2_bcd_step: assert property (@(posedge clk) disable iff (rst)
      (!clr[g] && !chain_sel[g]) |=>
        ((cnt_q[4*g +: 4] == $past(cnt_q[4*g +: 4])) ||
         (cnt_q[4*g +: 4] == bcd_succ($past(cnt_q[4*g +: 4])))));
    // R4
    a_r4_biq_step: assert property (@(posedge clk) disable iff (rst)
      (!clr[g] && chain_sel[g]) |=>
        ((cnt_q[4*g +: 4] == $past(cnt_q[4*g +: 4])) ||
         (cnt_q[4*g +: 4] == biq_succ($past(cnt_q[4*g +: 4])))));
  end
endmodule

bind decade_pair decade_pair_chk #(.NUM_CNT(NUM_CNT)) u_chk (.*);

// File: tb/tb_decade_pair.sv
`timescale 1ns/1ps
module tb_decade_pair;
  localparam int N = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst;
  logic [N-1:0]   clr, chain_sel, two_drv, tick_two, tick_five;
  logic           cascade;
  logic [4*N-1:0] cnt_q;

  always_comb begin
    tick_two = two_drv;
    if (cascade) tick_two[1] = cnt_q[0];
  end

  decade_pair #(.NUM_CNT(N)) dut (
    .clk(clk), .rst(rst), .clr(clr), .chain_sel(chain_sel),
    .tick_two(tick_two), .tick_five(tick_five), .cnt_q(cnt_q)
  );

  typedef struct {
    string      tag;
    int         idx;
    logic [3:0] exp;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    checks = 0, errors = 0;
  int    cnt [N];
  bit    bad_code = 1'b0;

  function automatic logic [3:0] enc(int v, logic biq);
    logic [3:0] r;
    if (!biq) begin
      r = 4'(v);
    end else begin
      r[3:1] = 3'(v % 5);
      r[0]   = (v >= 5);
    end
    return r;
  endfunction

  task automatic expect_all(string tag);
    for (int i = 0; i < N; i++) begin
      item_t it;
      it.tag = tag; it.idx = i; it.exp = enc(cnt[i], chain_sel[i]);
      sb.push_back(it);
    end
    -> chk_ev;
  endtask

  // monitor: pops expectations and compares away from the clock edge
  initial forever begin
    @(chk_ev);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (cnt_q[4*it.idx +: 4] !== it.exp) begin
        errors++;
        $display("FAIL %s counter %0d actual %b expected %b",
                 it.tag, it.idx, cnt_q[4*it.idx +: 4], it.exp);
      end
    end
  end

  // R11: quinary code range watched on every cycle
  always @(negedge clk) begin
    if (!rst)
      for (int i = 0; i < N; i++)
        if (cnt_q[4*i+1 +: 3] > 3'd4) bad_code = 1'b1;
  end

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_two(int i);
    two_drv[i] = 1'b1; step();
    two_drv[i] = 1'b0; step();
  endtask

  task automatic pulse_five(int i);
    tick_five[i] = 1'b1; step();
    tick_five[i] = 1'b0; step();
  endtask

  task automatic clear_all();
    clr = '1; step(); clr = '0; step();
    for (int i = 0; i < N; i++) cnt[i] = 0;
  endtask

  initial begin
    rst = 1'b1; clr = '0; chain_sel = '0; two_drv = '0; tick_five = '0;
    cascade = 1'b0;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    step(); step();
    expect_all("R1 reset");
    rst = 1'b0; step();

    // R2: BCD counting with wrap
    for (int k = 0; k < 12; k++) begin
      pulse_two(0);
      cnt[0] = (cnt[0] + 1) % 10;
      expect_all("R2 bcd count");
    end

    // R7: level high, then a single falling edge, then level low
    two_drv[0] = 1'b1; step(); step(); step();
    expect_all("R7 held high");
    two_drv[0] = 1'b0; step();
    cnt[0] = (cnt[0] + 1) % 10;
    expect_all("R7 one edge");
    step(); step(); step();
    expect_all("R7 held low");

    // R3: five-stage strobe ignored in BCD
    for (int k = 0; k < 3; k++) pulse_five(0);
    expect_all("R3 bcd ignores five strobe");

    // switch both to bi-quinary after a clear (R8)
    chain_sel = '1;
    clear_all();
    expect_all("R8 clear to zero");

    // R4 R6: full bi-quinary cycle on counter 1
    for (int k = 0; k < 10; k++) begin
      pulse_five(1);
      cnt[1] = (cnt[1] + 1) % 10;
      expect_all("R4 R6 biq count");
    end

    // R5: toggle strobe ignored in bi-quinary
    for (int k = 0; k < 3; k++) pulse_two(1);
    expect_all("R5 biq ignores two strobe");

    // R8: clear beats a simultaneous edge, neighbour untouched
    for (int k = 0; k < 3; k++) begin pulse_five(0); cnt[0]++; end
    for (int k = 0; k < 2; k++) begin pulse_five(1); cnt[1]++; end
    expect_all("R8 setup");
    tick_five[0] = 1'b1; step();
    tick_five[0] = 1'b0; clr[0] = 1'b1; step();
    clr[0] = 1'b0;
    cnt[0] = 0;
    expect_all("R8 clear priority");
    step(); step();
    expect_all("R9 no edge after release");

    // R9: strobe falls while clear is held, still low at release
    for (int k = 0; k < 2; k++) begin pulse_five(0); cnt[0]++; end
    tick_five[0] = 1'b1; step();
    clr[0] = 1'b1; step();
    tick_five[0] = 1'b0; step(); step();
    clr[0] = 1'b0; step(); step(); step();
    cnt[0] = 0;
    expect_all("R9 fall during clear");

    // R10: cascade to divide by 100
    chain_sel = 2'b01;
    clear_all();
    cascade = 1'b1;
    for (int k = 0; k < 55; k++) pulse_five(0);
    step();
    cnt[0] = 5; cnt[1] = 5;
    expect_all("R10 cascade 55");
    for (int k = 0; k < 45; k++) pulse_five(0);
    step();
    cnt[0] = 0; cnt[1] = 0;
    expect_all("R10 cascade 100");
    cascade = 1'b0;

    // R1: reset in the middle of a run
    for (int k = 0; k < 4; k++) pulse_five(0);
    rst = 1'b1; step(); rst = 1'b0;
    cnt[0] = 0; cnt[1] = 0;
    expect_all("R1 mid-run reset");
    step();

    // R11 final tally
    checks++;
    if (bad_code) begin
      errors++;
      $display("FAIL R11 quinary code above 4 seen actual 1 expected 0");
    end

    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule